// File: doc/BRIEF.md
# Sampling Phase Tuning Sweep Controller

This controller finds a good receive sampling phase for a card interface. On a start pulse it re-initialises an external programmable delay line, then walks through 16 delay phases in ascending order. For each phase it programs the delay line, issues a tuning-block read on a command port, and checks the returned byte stream against a reference pattern generated on chip. Each phase gets one pass bit. When all 16 phases have been tried, a window selector picks a phase from the longest run of passing phases. The controller programs that phase into the delay line and keeps it as the saved phase.

The host requests a double-data-rate high-speed mode by holding `hs_ddr` high when it pulses `start`. If a sweep has already completed and no calibration has yet succeeded, that request does not start a new sweep. The controller instead re-initialises the delay line, re-applies the saved phase, and waits for the calibration engine to report completion. All handshakes are request/acknowledge pairs. The requester holds `req` until it sees a single-cycle `ack`.

The state machine has ten states. `S_IDLE` waits for `start`. `S_INIT` re-initialises the delay line. `S_SETP` programs the current phase. `S_READ` runs the tuning read. `S_PICK` consults the selector. `S_APPLY` programs the chosen phase. `S_CINIT` and `S_CSET` re-initialise the delay line and re-apply the saved phase. `S_CWAIT` waits for calibration. `S_FIN` is the one-cycle end state.

The transitions are:
- `S_IDLE` goes to `S_CINIT` on start when the calibration path applies, and to `S_INIT` on any other start.
- `S_INIT` goes to `S_SETP` on delay acknowledge.
- `S_SETP` goes to `S_READ` on delay acknowledge.
- `S_READ` goes back to `S_SETP` on command acknowledge, or to `S_PICK` after the last phase. It goes to `S_FIN` on command timeout.
- `S_PICK` goes to `S_APPLY`, or to `S_FIN` when no phase passed.
- `S_APPLY` goes to `S_FIN` on acknowledge.
- `S_CINIT` goes to `S_CSET` on acknowledge.
- `S_CSET` goes to `S_CWAIT` on acknowledge.
- `S_CWAIT` goes to `S_FIN` on calibration done or on calibration timeout.
- `S_FIN` goes to `S_IDLE`.

Top module: `phase_sweep_ctrl`

## Requirements
- R1: A sweep first issues one delay operation with `dly_init`=1 and `dly_phase`=0. It then issues delay operations with `dly_init`=0 for phases 0,1,...,15 in order, and each is acknowledged before that phase's read command is raised.
- R2: The reference byte at stream index i is ((i*29) mod 256) XOR 0xA5 with a 128-byte length when `wide_bus`=1. It is ((i*13) mod 256) XOR 0x3C with a 64-byte length when `wide_bus`=0. The bus width is sampled at `start`.
- R3: A phase passes only when three conditions hold: its command acknowledge carries `cmd_err`=0, exactly the reference length of bytes arrived before that acknowledge, and every byte matched. A short stream, an extra byte, a corrupted byte or `cmd_err` each fail that phase.
- R4: The selected phase comes from the longest run of passing phases. A run wraps from 15 to 0 unless all 16 pass. When runs are equal, the run whose first phase is lowest wins. The result is the first phase of the run plus an offset, modulo 16. The offset is floor(3*L/4)-1, clamped at 0, where L is the run length.
- R5: After a sweep with at least one pass, one final delay operation with `dly_init`=0 applies the selected phase, and `saved_phase` takes that value. `saved_phase` changes at no other time.
- R6: If no phase passes, `fail`=1, no final delay operation occurs, and `saved_phase` keeps its value.
- R7: If a read command is not acknowledged within CMD_TIMEOUT cycles, the sweep stops at once with `fail`=1, and `saved_phase` keeps its value.
- R8: `busy` is high from the cycle after `start` until `op_done`, which lasts one cycle. In that cycle `fail`, `saved_phase` and `cal_ok` show the result. `tuned` is 1 from the next cycle on, whether the outcome was pass or fail.
- R9: A `start` with `hs_ddr`=1 while `tuned`=1 and `cal_ok`=0 runs the calibration path instead of a sweep. That path issues one delay operation with `dly_init`=1, then one with `dly_init`=0 and the saved phase, and no read command.
- R10: On the calibration path, `cal_done` with `cal_err`=0 sets `cal_ok` and leaves `fail`=0. `cal_done` with `cal_err`=1, or no `cal_done` within CAL_TIMEOUT cycles, gives `fail`=1 and leaves `cal_ok`=0.
- R11: Once `cal_ok`=1, a `start` with `hs_ddr`=1 runs a normal sweep.
- R12: After reset, `busy`, `tuned`, `cal_ok`, `fail`, `dly_req` and `cmd_req` are 0 and `saved_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| wide_bus | input | 1 | 1 selects the 8-bit bus pattern, 0 the 4-bit pattern |
| hs_ddr | input | 1 | Double-data-rate high-speed mode requested |
| dly_req | output | 1 | Delay-line operation request |
| dly_init | output | 1 | 1 = re-initialise the delay line, 0 = set the phase |
| dly_phase | output | 4 | Phase to program |
| dly_ack | input | 1 | Delay-line acknowledge, one cycle |
| cmd_req | output | 1 | Tuning-read command request |
| cmd_ack | input | 1 | Command completion, one cycle |
| cmd_err | input | 1 | Command error, qualified by `cmd_ack` |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| cal_done | input | 1 | Calibration finished |
| cal_err | input | 1 | Calibration error, qualified by `cal_done` |
| busy | output | 1 | Tuning in progress |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| tuned | output | 1 | A tuning operation has completed |
| cal_ok | output | 1 | Calibration has succeeded |
| fail | output | 1 | Outcome of the last operation |
| saved_phase | output | 4 | Saved tuned phase |

## Verification
Delay acknowledges are driven at a falling edge. The bench compares `dly_init`/`dly_phase` against the queued expected operation at that same moment, while the request is steady, and checks `busy` there as well. Results are due in the cycle where `op_done` is high. The bench therefore polls `op_done` at falling edges and samples `fail`, `saved_phase` and `cal_ok` in that very cycle. It samples `tuned` and `busy` one cycle later. Read-command bytes start at the first falling edge after `cmd_req` rises, and the acknowledge follows the last byte, so every stream length the bench intends is counted exactly.

// File: rtl/phase_sweep_pkg.sv
package phase_sweep_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_INIT, S_SETP, S_READ, S_PICK,
        S_APPLY, S_CINIT, S_CSET, S_CWAIT, S_FIN
    } sweep_state_t;
endpackage

// File: rtl/tune_pattern_rom.sv
module tune_pattern_rom #(
    parameter int AW = 7
) (
    input  logic          wide,
    input  logic [AW-1:0] idx,
    output logic [7:0]    data
);
    logic [7:0] i8;
    always_comb begin
        i8 = 8'(idx);
        if (wide) data = 8'(i8 * 8'd29) ^ 8'hA5;
        else      data = 8'(i8 * 8'd13) ^ 8'h3C;
    end
endmodule

// File: rtl/phase_window_sel.sv
module phase_window_sel #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] sel,
    output logic         none
);
    int  best_len, best_start, run_len, off;
    logic run, full, is_start;

    always_comb begin
        full = &mask;
        best_len = 0;
        best_start = 0;
        for (int s = 0; s < N; s++) begin
            is_start = mask[s] && (full ? (s == 0) : !mask[(s + N - 1) % N]);
            run_len = 0;
            run = 1'b1;
            for (int k = 0; k < N; k++) begin
                if (run && mask[(s + k) % N]) run_len++;
                else run = 1'b0;
            end
            if (is_start && run_len > best_len) begin
                best_len = run_len;
                best_start = s;
            end
        end
        off = (best_len * 3) / 4;
        if (off > 0) off--;
        sel = W'((best_start + off) % N);
        none = (best_len == 0);
    end

    always_comb begin
        if (!none) AST_SEL_PASSES: assert (mask[sel]); // R4
    end
endmodule

// File: rtl/phase_sweep_ctrl.sv
module phase_sweep_ctrl
    import phase_sweep_pkg::*;
#(
    parameter int PHASES      = 16,
    parameter int WIDE_LEN    = 128,
    parameter int NARROW_LEN  = 64,
    parameter int CMD_TIMEOUT = 512,
    parameter int CAL_TIMEOUT = 2000,
    localparam int PW   = $clog2(PHASES),
    localparam int AW   = $clog2(WIDE_LEN),
    localparam int CW   = $clog2(WIDE_LEN + 2),
    localparam int TMAX = (CMD_TIMEOUT > CAL_TIMEOUT) ? CMD_TIMEOUT : CAL_TIMEOUT,
    localparam int TW   = $clog2(TMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wide_bus,
    input  logic          hs_ddr,
    output logic          dly_req,
    output logic          dly_init,
    output logic [PW-1:0] dly_phase,
    input  logic          dly_ack,
    output logic          cmd_req,
    input  logic          cmd_ack,
    input  logic          cmd_err,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          cal_done,
    input  logic          cal_err,
    output logic          busy,
    output logic          op_done,
    output logic          tuned,
    output logic          cal_ok,
    output logic          fail,
    output logic [PW-1:0] saved_phase
);
    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);
    localparam logic [PW-1:0] ONE_PH  = PW'(1);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    sweep_state_t  state_q, state_d;
    logic [PW-1:0] phase_q, saved_q, sel_phase;
    logic [PHASES-1:0] mask_q;
    logic [CW-1:0] cnt_q, len_w;
    logic [TW-1:0] tmo_q;
    logic          wide_q, bad_q, fail_q, tuned_q, cal_ok_q;
    logic          sel_none, cal_path, cmd_tmo, cal_tmo;
    logic [7:0]    ref_byte;

    tune_pattern_rom #(.AW(AW)) u_rom (
        .wide(wide_q), .idx(cnt_q[AW-1:0]), .data(ref_byte)
    );

    phase_window_sel #(.N(PHASES)) u_sel (
        .mask(mask_q), .sel(sel_phase), .none(sel_none)
    );

    assign len_w    = wide_q ? CW'(WIDE_LEN) : CW'(NARROW_LEN);
    assign cal_path = tuned_q && !cal_ok_q && hs_ddr;
    assign cmd_tmo  = (tmo_q == TW'(CMD_TIMEOUT - 1));
    assign cal_tmo  = (tmo_q == TW'(CAL_TIMEOUT - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = cal_path ? S_CINIT : S_INIT;
            S_INIT:  if (dly_ack) state_d = S_SETP;
            S_SETP:  if (dly_ack) state_d = S_READ;
            S_READ: begin
                if (cmd_ack) state_d = (phase_q == LAST_PH) ? S_PICK : S_SETP;
                else if (cmd_tmo) state_d = S_FIN;
            end
            S_PICK:  state_d = sel_none ? S_FIN : S_APPLY;
            S_APPLY: if (dly_ack) state_d = S_FIN;
            S_CINIT: if (dly_ack) state_d = S_CSET;
            S_CSET:  if (dly_ack) state_d = S_CWAIT;
            S_CWAIT: if (cal_done || cal_tmo) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        dly_req   = 1'b0;
        dly_init  = 1'b0;
        dly_phase = '0;
        cmd_req   = 1'b0;
        unique case (state_q)
            S_INIT, S_CINIT: begin dly_req = 1'b1; dly_init = 1'b1; end
            S_SETP:  begin dly_req = 1'b1; dly_phase = phase_q; end
            S_APPLY: begin dly_req = 1'b1; dly_phase = sel_phase; end
            S_CSET:  begin dly_req = 1'b1; dly_phase = saved_q; end
            S_READ:  cmd_req = 1'b1;
            default: ;
        endcase
        busy        = (state_q != S_IDLE);
        op_done     = (state_q == S_FIN);
        tuned       = tuned_q;
        cal_ok      = cal_ok_q;
        fail        = fail_q;
        saved_phase = saved_q;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            saved_q  <= '0;
            mask_q   <= '0;
            cnt_q    <= '0;
            tmo_q    <= '0;
            wide_q   <= 1'b0;
            bad_q    <= 1'b0;
            fail_q   <= 1'b0;
            tuned_q  <= 1'b0;
            cal_ok_q <= 1'b0;
        end else begin
            if (state_d == S_FIN) tuned_q <= 1'b1;
            case (state_q)
                S_IDLE: if (start) begin
                    wide_q  <= wide_bus;
                    phase_q <= '0;
                    mask_q  <= '0;
                    fail_q  <= 1'b0;
                end
                S_SETP: if (dly_ack) begin
                    cnt_q <= '0;
                    bad_q <= 1'b0;
                    tmo_q <= '0;
                end
                S_READ: begin
                    tmo_q <= tmo_q + 1'b1;
                    if (rx_valid) begin
                        if (cnt_q >= len_w || rx_byte != ref_byte) bad_q <= 1'b1;
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end
                    if (cmd_ack) begin
                        mask_q[phase_q] <= !cmd_err && !bad_q && (cnt_q == len_w);
                        if (phase_q != LAST_PH) phase_q <= phase_q + ONE_PH;
                    end else if (cmd_tmo) begin
                        fail_q <= 1'b1;
                    end
                end
                S_PICK:  if (sel_none) fail_q <= 1'b1;
                S_APPLY: if (dly_ack) saved_q <= sel_phase;
                S_CSET:  if (dly_ack) tmo_q <= '0;
                S_CWAIT: begin
                    tmo_q <= tmo_q + 1'b1;
                    if (cal_done) begin
                        if (cal_err) fail_q <= 1'b1;
                        else         cal_ok_q <= 1'b1;
                    end else if (cal_tmo) begin
                        fail_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(dly_req && cmd_req)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (phase_q == $past(phase_q) + ONE_PH || phase_q == '0)); // R1
    AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == S_APPLY && dly_ack) |=> $stable(saved_q)); // R5
    AST_FAIL_NO_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_APPLY) |-> !fail_q); // R6
    AST_DONE_TUNED: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (!busy && tuned)); // R8
    AST_CAL_NEEDS_TUNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CINIT) |-> (tuned_q && !cal_ok_q)); // R9
endmodule

// File: tb/phase_sweep_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_sweep_ctrl_tb_top;
    localparam int GOOD = 0, CORRUPT = 1, CERR = 2, SHORT = 3, EXTRA = 4, HANG = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, wide_bus = 0, hs_ddr = 0;
    logic dly_req, dly_init, dly_ack = 0;
    logic [3:0] dly_phase, saved_phase;
    logic cmd_req, cmd_ack = 0, cmd_err = 0, rx_valid = 0;
    logic [7:0] rx_byte = 0;
    logic cal_done = 0, cal_err = 0;
    logic busy, op_done, tuned, cal_ok, fail;

    int n_chk = 0, n_fail = 0, cmd_idx = 0;
    int beh [16];
    int exp_q [$];

    always #2.5 clk = ~clk;

    phase_sweep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_bus(wide_bus), .hs_ddr(hs_ddr),
        .dly_req(dly_req), .dly_init(dly_init), .dly_phase(dly_phase), .dly_ack(dly_ack),
        .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .cal_done(cal_done), .cal_err(cal_err),
        .busy(busy), .op_done(op_done), .tuned(tuned), .cal_ok(cal_ok), .fail(fail),
        .saved_phase(saved_phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input bit wide, input int i);
        return wide ? (8'(i * 29) ^ 8'hA5) : (8'(i * 13) ^ 8'h3C);
    endfunction

    // Scoreboard driver side: expected delay operations (16 = re-init)
    task automatic push_sweep(input int applied);
        exp_q.push_back(16);
        for (int p = 0; p < 16; p++) exp_q.push_back(p);
        if (applied >= 0) exp_q.push_back(applied);
    endtask

    // Delay responder and scoreboard monitor
    always @(negedge clk) begin
        if (dly_ack) dly_ack = 1'b0;
        else if (dly_req) begin
            dly_ack = 1'b1;
            if (exp_q.size() == 0) check(0, "R1 unexpected delay op", {dly_init, dly_phase}, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                check({27'd0, dly_init, dly_phase} == e, "R1/R5/R9 delay op", {dly_init, dly_phase}, e);
            end
            check(busy == 1'b1, "R8 busy during op", busy, 1);
        end
    end

    // Command responder
    initial forever begin
        @(negedge clk);
        if (cmd_req) begin
            int b, n, len;
            b = beh[cmd_idx % 16];
            cmd_idx++;
            len = wide_bus ? 128 : 64;
            n = (b == SHORT) ? len - 1 : (b == EXTRA) ? len + 1 : len;
            for (int i = 0; i < n; i++) begin
                rx_valid = 1'b1;
                rx_byte = pat(wide_bus, i) ^ ((b == CORRUPT && i == 5) ? 8'h10 : 8'h00);
                @(negedge clk);
            end
            rx_valid = 1'b0;
            if (b == HANG) begin
                while (cmd_req) @(negedge clk);
            end else begin
                cmd_ack = 1'b1;
                cmd_err = (b == CERR);
                @(negedge clk);
                cmd_ack = 1'b0;
                cmd_err = 1'b0;
            end
        end
    end

    task automatic run_op(input bit wide, input bit hs, input bit exp_fail,
                          input int exp_saved, input bit exp_cal, input int exp_cmds,
                          input string tag);
        cmd_idx = 0;
        wide_bus = wide;
        hs_ddr = hs;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!op_done) @(negedge clk);
        check(fail == exp_fail, {tag, " fail"}, fail, exp_fail);
        check(saved_phase == exp_saved, {tag, " saved_phase"}, saved_phase, exp_saved);
        check(cal_ok == exp_cal, {tag, " cal_ok"}, cal_ok, exp_cal);
        check(cmd_idx == exp_cmds, {tag, " read commands"}, cmd_idx, exp_cmds);
        check(exp_q.size() == 0, {tag, " delay ops outstanding"}, exp_q.size(), 0);
        @(negedge clk);
        check(tuned == 1'b1, "R8 tuned after op", tuned, 1);
        check(busy == 1'b0, "R8 busy cleared", busy, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(busy == 0 && tuned == 0 && cal_ok == 0 && fail == 0, "R12 flags", {busy, tuned, cal_ok, fail}, 0);
        check(dly_req == 0 && cmd_req == 0 && saved_phase == 0, "R12 ports", {dly_req, cmd_req, saved_phase}, 0);

        // R2 R4: wide bus, all pass -> phase 11
        for (int p = 0; p < 16; p++) beh[p] = GOOD;
        push_sweep(11);
        run_op(1, 0, 0, 11, 0, 16, "R2 R4 all pass wide");

        // R3: narrow bus, only phase 7 clean
        for (int p = 0; p < 16; p++) beh[p] = 1 + (p % 4);
        beh[7] = GOOD;
        push_sweep(7);
        run_op(0, 0, 0, 7, 0, 16, "R3 single pass narrow");

        // R4: wrap run 13..1 (len 5) beats 5..7 -> 15
        for (int p = 0; p < 16; p++) beh[p] = CORRUPT;
        foreach (beh[p]) if (p >= 13 || p <= 1 || (p >= 5 && p <= 7)) beh[p] = GOOD;
        push_sweep(15);
        run_op(1, 0, 0, 15, 0, 16, "R4 wrap run");

        // R4: tie between 2..5 and 9..12 -> earliest, 4
        for (int p = 0; p < 16; p++) beh[p] = SHORT;
        foreach (beh[p]) if ((p >= 2 && p <= 5) || (p >= 9 && p <= 12)) beh[p] = GOOD;
        push_sweep(4);
        run_op(0, 0, 0, 4, 0, 16, "R4 tie");

        // R6: nothing passes
        for (int p = 0; p < 16; p++) beh[p] = (p % 2) ? EXTRA : CERR;
        push_sweep(-1);
        run_op(1, 0, 1, 4, 0, 16, "R6 no pass");

        // R7: command timeout at phase 3
        for (int p = 0; p < 16; p++) beh[p] = GOOD;
        beh[3] = HANG;
        exp_q.push_back(16);
        for (int p = 0; p < 4; p++) exp_q.push_back(p);
        run_op(1, 0, 1, 4, 0, 4, "R7 command timeout");

        // R9 R10: calibration error
        cal_done = 1'b1; cal_err = 1'b1;
        exp_q.push_back(16); exp_q.push_back(4);
        run_op(1, 1, 1, 4, 0, 0, "R9 R10 cal error");

        // R10: calibration timeout
        cal_done = 1'b0; cal_err = 1'b0;
        exp_q.push_back(16); exp_q.push_back(4);
        run_op(1, 1, 1, 4, 0, 0, "R10 cal timeout");

        // R10: calibration success
        cal_done = 1'b1;
        exp_q.push_back(16); exp_q.push_back(4);
        run_op(0, 1, 0, 4, 1, 0, "R10 cal ok");
        cal_done = 1'b0;

        // R11: high-speed request after calibration runs a sweep
        for (int p = 0; p < 16; p++) beh[p] = GOOD;
        push_sweep(11);
        run_op(1, 1, 0, 11, 1, 16, "R11 sweep after cal");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule